// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block connects a clocked host to an external 64K x 16 asynchronous static RAM. The host presents a request with a word address, write data, a two-bit lane mask and a read/write flag. The controller then runs one complete memory cycle. It drives the active-low chip select, write strobe, output strobe and per-lane enables, and it owns one side of a shared tri-state data bus. The length of each phase is a whole number of clocks. Each count is computed at elaboration as the ceiling of a nanosecond limit divided by the clock period, with a minimum of one clock. A single grade parameter selects between the fast (70 ns) and slow (100 ns) limit sets.

States, all named `ST_*`:
- **IDLE**: deselected, ready.
- **RD_ACCESS**: chip, output strobe and the selected lanes are enabled. The bus is sampled on the last clock of this state.
- **WR_TURN**: write strobe low, own drivers still off, to let the memory release the bus.
- **WR_DRIVE**: write strobe low, data driven.
- **WR_RELEASE**: write strobe raised, data, address and chip select still held.
- **REST**: deselected recovery time before the next access.

Transitions:
- IDLE to RD_ACCESS on a read request with a non-zero mask.
- IDLE to WR_TURN on such a write request.
- RD_ACCESS to REST when the access count expires, with the captured data returned.
- WR_TURN to WR_DRIVE, then WR_DRIVE to WR_RELEASE, then WR_RELEASE to REST, each on count expiry.
- REST to IDLE on count expiry.
- A request whose mask is zero is taken in IDLE and leaves the state unchanged.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are 1, `ready` is 1 and `rd_valid` is 0.
- R2: `ready` is 1 only in IDLE, and `mem_cs_n` is 1 whenever `ready` is 1.
- R3: A write with mask `2'b11` stores all 16 bits at the addressed word, and a later word read returns them.
- R4: Mask bit 0 selects the low lane (bits 7..0) and bit 1 the high lane (bits 15..8). During an access `mem_be_n[i]` is the inverse of mask bit i, and a write leaves lanes with a clear mask bit unchanged in memory.
- R5: A read returns the enabled lanes on `rd_data` with the disabled lanes forced to zero. `rd_valid` is a single-clock pulse, once per read.
- R6: A request with mask `2'b00`, read or write, is a no-op. `mem_cs_n` stays 1, no `rd_valid` is produced, `ready` stays 1 and memory is unchanged.
- R7: A read holds `mem_cs_n`, `mem_oe_n` and the selected enables low, with `mem_we_n` high, for ceil(max(cycle, access)/clock) clocks before the bus is sampled. At 5 ns and the fast grade this is 14 clocks.
- R8: A write holds `mem_we_n` low for at least the write-pulse limit. The written data is on the bus at least the data-setup limit before `mem_we_n` rises. `mem_we_n` rises one clock before `mem_cs_n` rises and the drivers turn off. Address and enables are stable while `mem_cs_n` is low.
- R9: The controller drives `mem_dq` only while `mem_oe_n` is high and `mem_cs_n` is low. It starts driving no sooner than the bus-release limit (25 ns fast) after `mem_we_n` falls. `mem_we_n` and `mem_oe_n` are never both low.
- R10: After each access, `mem_cs_n` stays high for ceil(cycle/clock) clocks before the next fall. `ready` is low from acceptance until that recovery ends: at 5 ns fast, 28 clocks for a read and 5+6+1+14 = 26 clocks for a write.
- R11: With the slow grade selected, the same clock gives 40 busy clocks per read and 6+8+1+20 = 35 per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANES | Write data |
| req_mask | input | LANES | Lane select, bit i = byte i |
| ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | 8*LANES | Read result, disabled lanes zero |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_be_n | output | LANES | Lane enables, active low |
| mem_dq | inout | 8*LANES | Shared data bus |

## Verification
The hardest case to reach from the ports is a read that samples the bus too early. A simple memory model would already hold valid data, so early sampling would go unnoticed. The bench's memory model therefore drives a decoy pattern until almost the full access time has passed after chip select falls. Only a controller that waits the complete count returns the stored word.

Bus turnaround is also invisible to host-side data checks. The model timestamps the fall of the write strobe, the first instant the bus carries the written word, and the strobe's rise. It checks the release, setup and pulse limits against those times.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_TURN,
        ST_WR_DRIVE,
        ST_WR_RELEASE,
        ST_REST
    } sram_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // ceiling of ns over the clock period, never below one clock
    function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_tick_counter.sv
`timescale 1ns/1ps
module sram_tick_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_byte_lanes.sv
`timescale 1ns/1ps
module sram_byte_lanes #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   mask_q,
    input  logic               lanes_on,
    input  logic               capture,
    input  logic [8*LANES-1:0] dq_in,
    output logic [LANES-1:0]   be_n,
    output logic [8*LANES-1:0] rd_data,
    output logic               rd_valid
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_n[i] = ~(lanes_on & mask_q[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_data[8*i +: 8] <= '0;
            else if (capture)
                rd_data[8*i +: 8] <= mask_q[i] ? dq_in[8*i +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= capture;
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CLK   = 14,
    parameter int unsigned TURN_CLK = 5,
    parameter int unsigned DRV_CLK  = 6,
    parameter int unsigned REST_CLK = 14,
    parameter int          CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             req_mask_any,
    input  logic             cnt_zero,
    output logic             start,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ready,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             lanes_on,
    output logic             dq_drive,
    output logic             capture
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CLK - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CLK - 1);
    localparam logic [CNT_W-1:0] DRV_LD  = CNT_W'(DRV_CLK - 1);
    localparam logic [CNT_W-1:0] REST_LD = CNT_W'(REST_CLK - 1);

    sram_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions and phase lengths
    always_comb begin
        state_nx = state;
        cnt_val  = '0;
        start    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req && req_mask_any) begin
                    start    = 1'b1;
                    state_nx = req_we ? ST_WR_TURN : ST_RD_ACCESS;
                    cnt_val  = req_we ? TURN_LD : RD_LD;
                end
            end
            ST_RD_ACCESS: if (cnt_zero) begin
                state_nx = ST_REST;
                cnt_val  = REST_LD;
            end
            ST_WR_TURN: if (cnt_zero) begin
                state_nx = ST_WR_DRIVE;
                cnt_val  = DRV_LD;
            end
            ST_WR_DRIVE: if (cnt_zero) begin
                state_nx = ST_WR_RELEASE;
                cnt_val  = '0;
            end
            ST_WR_RELEASE: if (cnt_zero) begin
                state_nx = ST_REST;
                cnt_val  = REST_LD;
            end
            ST_REST: if (cnt_zero) begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign cnt_load = (state_nx != state);

    // outputs decoded from the state register
    always_comb begin
        ready    = 1'b0;
        cs_n     = 1'b1;
        we_n     = 1'b1;
        oe_n     = 1'b1;
        lanes_on = 1'b0;
        dq_drive = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE:      ready = 1'b1;
            ST_RD_ACCESS: begin
                cs_n     = 1'b0;
                oe_n     = 1'b0;
                lanes_on = 1'b1;
                capture  = cnt_zero;
            end
            ST_WR_TURN: begin
                cs_n     = 1'b0;
                we_n     = 1'b0;
                lanes_on = 1'b1;
            end
            ST_WR_DRIVE: begin
                cs_n     = 1'b0;
                we_n     = 1'b0;
                lanes_on = 1'b1;
                dq_drive = 1'b1;
            end
            ST_WR_RELEASE: begin
                cs_n     = 1'b0;
                lanes_on = 1'b1;
                dq_drive = 1'b1;
            end
            ST_REST: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS     = 5,
    parameter bit          SLOW_GRADE = 1'b0,
    parameter int          ADDR_W     = 16,
    parameter int          LANES      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [8*LANES-1:0]    req_wdata,
    input  logic [LANES-1:0]      req_mask,
    output logic                  ready,
    output logic [8*LANES-1:0]    rd_data,
    output logic                  rd_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_cs_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [LANES-1:0]      mem_be_n,
    inout  wire  [8*LANES-1:0]    mem_dq
);
    localparam int DATA_W = 8 * LANES;

    // limits in ns for the selected grade
    localparam int unsigned T_CYCLE_NS   = SLOW_GRADE ? 100 : 70;
    localparam int unsigned T_ACCESS_NS  = SLOW_GRADE ? 100 : 70;
    localparam int unsigned T_STROBE_NS  = SLOW_GRADE ? 50  : 35;
    localparam int unsigned T_WPULSE_NS  = SLOW_GRADE ? 70  : 55;
    localparam int unsigned T_DSETUP_NS  = SLOW_GRADE ? 40  : 30;
    localparam int unsigned T_RELEASE_NS = SLOW_GRADE ? 30  : 25;

    localparam int unsigned RD_CLK   = clocks_for(max2(T_CYCLE_NS, max2(T_ACCESS_NS, T_STROBE_NS)), CLK_NS);
    localparam int unsigned TURN_CLK = clocks_for(T_RELEASE_NS, CLK_NS);
    localparam int unsigned WP_CLK   = clocks_for(T_WPULSE_NS, CLK_NS);
    localparam int unsigned DRV_CLK  = max2(clocks_for(T_DSETUP_NS, CLK_NS),
                                            (WP_CLK > TURN_CLK) ? (WP_CLK - TURN_CLK) : 1);
    localparam int unsigned REST_CLK = clocks_for(T_CYCLE_NS, CLK_NS);
    localparam int unsigned MAX_CLK  = max2(max2(RD_CLK, TURN_CLK), max2(DRV_CLK, REST_CLK));
    localparam int          CNT_W    = $clog2(MAX_CLK + 1);

    logic                 start, cnt_load, cnt_zero;
    logic [CNT_W-1:0]     cnt_val;
    logic                 lanes_on, dq_drive, capture;
    logic [LANES-1:0]     mask_q;
    logic [DATA_W-1:0]    wdata_q;

    // request registers, held for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mask_q   <= '0;
            wdata_q  <= '0;
        end else if (start) begin
            mem_addr <= req_addr;
            mask_q   <= req_mask;
            wdata_q  <= req_wdata;
        end
    end

    sram_ctrl_fsm #(
        .RD_CLK   (RD_CLK),
        .TURN_CLK (TURN_CLK),
        .DRV_CLK  (DRV_CLK),
        .REST_CLK (REST_CLK),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .req_we       (req_we),
        .req_mask_any (|req_mask),
        .cnt_zero     (cnt_zero),
        .start        (start),
        .cnt_load     (cnt_load),
        .cnt_val      (cnt_val),
        .ready        (ready),
        .cs_n         (mem_cs_n),
        .we_n         (mem_we_n),
        .oe_n         (mem_oe_n),
        .lanes_on     (lanes_on),
        .dq_drive     (dq_drive),
        .capture      (capture)
    );

    sram_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_byte_lanes #(.LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_q   (mask_q),
        .lanes_on (lanes_on),
        .capture  (capture),
        .dq_in    (mem_dq),
        .be_n     (mem_be_n),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_dq = dq_drive ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              dq_drive
);
    p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_cs_n);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_no_empty_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> ((~mem_be_n) != '0));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    p_we_before_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> $past(mem_we_n));

    p_strobes_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_drive_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (mem_oe_n && !mem_cs_n));

    p_drive_after_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drive) |-> ($past(!mem_we_n) && !mem_we_n));

    p_valid_in_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_cs_n && !ready));
endmodule

bind sram_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_be_n (mem_be_n),
    .dq_drive (dq_drive)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int nvec = 0;
    int nmis = 0;
    bit done = 1'b0;

    // fast-grade instance with memory model
    logic        m_req = 0, m_we = 0;
    logic [15:0] m_addr = 0, m_wdata = 0;
    logic [1:0]  m_mask = 0;
    logic        m_ready, m_vld;
    logic [15:0] m_rd;
    logic [15:0] m_maddr;
    logic        m_cs_n, m_we_n, m_oe_n;
    logic [1:0]  m_be_n;
    wire  [15:0] m_dq;

    sram_ctrl u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(m_req), .req_we(m_we), .req_addr(m_addr),
        .req_wdata(m_wdata), .req_mask(m_mask), .ready(m_ready), .rd_data(m_rd),
        .rd_valid(m_vld), .mem_addr(m_maddr), .mem_cs_n(m_cs_n), .mem_we_n(m_we_n),
        .mem_oe_n(m_oe_n), .mem_be_n(m_be_n), .mem_dq(m_dq));

    // slow-grade instance, timing only
    logic        s_req = 0, s_we = 0;
    logic [15:0] s_addr = 0, s_wdata = 0;
    logic [1:0]  s_mask = 0;
    logic        s_ready, s_vld;
    logic [15:0] s_rd, s_maddr;
    logic        s_cs_n, s_we_n, s_oe_n;
    logic [1:0]  s_be_n;
    wire  [15:0] s_dq;

    sram_ctrl #(.SLOW_GRADE(1'b1)) u_sram_ctrl_slow (
        .clk(clk), .rst_n(rst_n), .req(s_req), .req_we(s_we), .req_addr(s_addr),
        .req_wdata(s_wdata), .req_mask(s_mask), .ready(s_ready), .rd_data(s_rd),
        .rd_valid(s_vld), .mem_addr(s_maddr), .mem_cs_n(s_cs_n), .mem_we_n(s_we_n),
        .mem_oe_n(s_oe_n), .mem_be_n(s_be_n), .mem_dq(s_dq));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [0:255];
    bit  acc_ok = 0, had_access = 0, data_seen = 0;
    time t_cs_rise = 0, t_we_fall = 0, t_data = 0;
    logic [15:0] exp_wdata = 0;
    logic [15:0] rd_word;

    assign rd_word = acc_ok ? mem[m_maddr[7:0]] : 16'h5A3C;
    assign m_dq[7:0]  = (!m_cs_n && m_we_n && !m_oe_n && !m_be_n[0]) ? rd_word[7:0]  : 8'bz;
    assign m_dq[15:8] = (!m_cs_n && m_we_n && !m_oe_n && !m_be_n[1]) ? rd_word[15:8] : 8'bz;

    always @(posedge m_cs_n) t_cs_rise = $time;

    always @(negedge m_cs_n) begin
        acc_ok = 1'b0;
        if (had_access)
            chk("R10 cs high gap >= 70ns", 32'($time - t_cs_rise >= 70), 1);
        had_access = 1'b1;
        #69;
        acc_ok = 1'b1;   // R7: stored data only near the end of the access time
    end

    always @(negedge m_we_n) if (!m_cs_n) begin
        t_we_fall = $time;
        data_seen = 1'b0;
    end

    always @(m_dq) if (!m_cs_n && !m_we_n && !data_seen && m_dq === exp_wdata) begin
        data_seen = 1'b1;
        t_data = $time;
        chk("R9 drive starts >= 25ns after we fall", 32'($time - t_we_fall >= 25), 1);
    end

    always @(posedge m_we_n) if (!m_cs_n) begin
        chk("R8 we pulse >= 55ns", 32'($time - t_we_fall >= 55), 1);
        chk("R8 data seen before we rise", 32'(data_seen), 1);
        chk("R8 data setup >= 30ns", 32'($time - t_data >= 30), 1);
        if (!m_be_n[0]) mem[m_maddr[7:0]][7:0]  = m_dq[7:0];
        if (!m_be_n[1]) mem[m_maddr[7:0]][15:8] = m_dq[15:8];
    end

    // ---------------- host access ----------------
    task automatic host_cycle(input bit slow, input bit we, input logic [15:0] addr,
                              input logic [15:0] wd, input logic [1:0] mask,
                              output logic [15:0] rdata, output int busy, output int nvalid);
        @(negedge clk);
        while (!(slow ? s_ready : m_ready)) @(negedge clk);
        if (slow) begin s_req = 1; s_we = we; s_addr = addr; s_wdata = wd; s_mask = mask; end
        else begin
            m_req = 1; m_we = we; m_addr = addr; m_wdata = wd; m_mask = mask;
            if (we) exp_wdata = wd;
        end
        @(negedge clk);
        m_req = 0; s_req = 0;
        busy = 0; nvalid = 0; rdata = 16'hxxxx;
        while (!(slow ? s_ready : m_ready) && busy < 1000) begin
            busy++;
            if (slow ? s_vld : m_vld) begin
                nvalid++;
                rdata = slow ? s_rd : m_rd;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 cs_n", 32'(m_cs_n), 1);
        chk("R1 we_n", 32'(m_we_n), 1);
        chk("R1 oe_n", 32'(m_oe_n), 1);
        chk("R1 be_n", 32'(m_be_n), 32'h3);
        chk("R1 ready", 32'(m_ready), 1);
        chk("R1 rd_valid", 32'(m_vld), 0);
    endtask

    task automatic t_word;
        logic [15:0] d; int b, n;
        host_cycle(0, 1, 16'h0010, 16'h1234, 2'b11, d, b, n);
        chk("R10 write busy clocks", 32'(b), 26);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b11, d, b, n);
        chk("R3 word readback", 32'(d), 32'h1234);
        chk("R5 one valid pulse", 32'(n), 1);
        chk("R10 read busy clocks", 32'(b), 28);
        host_cycle(0, 1, 16'h0021, 16'hA55A, 2'b11, d, b, n);
        host_cycle(0, 0, 16'h0021, 16'h0000, 2'b11, d, b, n);
        chk("R3 second word", 32'(d), 32'hA55A);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b11, d, b, n);
        chk("R3 first word kept", 32'(d), 32'h1234);
    endtask

    task automatic t_lanes;
        logic [15:0] d; int b, n;
        host_cycle(0, 1, 16'h0010, 16'hFFAB, 2'b01, d, b, n);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b11, d, b, n);
        chk("R4 low-lane write only", 32'(d), 32'h12AB);
        host_cycle(0, 1, 16'h0010, 16'hCD99, 2'b10, d, b, n);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b11, d, b, n);
        chk("R4 high-lane write only", 32'(d), 32'hCDAB);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b01, d, b, n);
        chk("R5 low-lane read", 32'(d), 32'h00AB);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b10, d, b, n);
        chk("R5 high-lane read", 32'(d), 32'hCD00);
        chk("R5 one valid pulse lane read", 32'(n), 1);
    endtask

    task automatic t_lane_enable;
        bit seen_lo = 0, seen_hi = 0;
        @(negedge clk);
        m_req = 1; m_we = 0; m_addr = 16'h0021; m_mask = 2'b10;
        @(negedge clk);
        m_req = 0;
        chk("R4 be_n follows mask 10", 32'(m_be_n), 32'h1);
        chk("R7 read strobes", 32'({m_cs_n, m_oe_n, m_we_n}), 32'h1);
        for (int i = 0; i < 40; i++) begin
            if (m_vld) seen_hi = 1;
            @(negedge clk);
        end
        chk("R5 valid on lane read", 32'(seen_hi), 1);
        seen_lo = 0;
        chk("R2 ready after access", 32'(m_ready), 1);
    endtask

    task automatic t_zero_mask;
        logic [15:0] d; int b, n;
        bit cs_fell = 0, vld_seen = 0, rdy_low = 0;
        @(negedge clk);
        m_req = 1; m_we = 0; m_addr = 16'h0010; m_mask = 2'b00;
        @(negedge clk);
        m_req = 1; m_we = 1; m_wdata = 16'h0000;
        @(negedge clk);
        m_req = 0;
        for (int i = 0; i < 30; i++) begin
            if (!m_cs_n) cs_fell = 1;
            if (m_vld) vld_seen = 1;
            if (!m_ready) rdy_low = 1;
            @(negedge clk);
        end
        chk("R6 cs stays high", 32'(cs_fell), 0);
        chk("R6 no valid", 32'(vld_seen), 0);
        chk("R6 ready stays high", 32'(rdy_low), 0);
        host_cycle(0, 0, 16'h0010, 16'h0000, 2'b11, d, b, n);
        chk("R6 memory unchanged", 32'(d), 32'hCDAB);
    endtask

    task automatic t_slow;
        logic [15:0] d; int b, n;
        host_cycle(1, 1, 16'h0003, 16'h7777, 2'b11, d, b, n);
        chk("R11 slow write busy", 32'(b), 35);
        host_cycle(1, 0, 16'h0003, 16'h0000, 2'b01, d, b, n);
        chk("R11 slow read busy", 32'(b), 40);
        chk("R11 slow read valid once", 32'(n), 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_word();
        t_lanes();
        t_lane_enable();
        t_zero_mask();
        t_slow();
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++;
            nmis++;
            $display("FAIL watchdog all requirements: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end
endmodule